// File: doc/BRIEF.md
# Remote Reconfiguration Bus Bridge

This block connects a processor's memory-mapped slave port to a remote-reconfiguration engine. A 6-bit word address selects the operation. In the lower half of the space, the address is split into a 3-bit parameter code and a 2-bit source code. A read or write there becomes a single strobe toward the engine. The bus is held in wait states until the engine reports that it is no longer busy. Engine read data is narrower than the bus and is returned zero-extended.

In the upper half of the space, every offset maps onto one local control/status register. Bit 0 of this register drives the engine's reconfigure request. Bit 1 holds the engine's watchdog timer in reset. Software sets bit 1 and then clears it to restart the timer. Accesses to this register finish in a single cycle and never touch the engine.

Top module: `rup_bridge`

## Requirements
- R1: During an engine strobe, `eng_param_o` equals address bits [2:0] of the access that caused it.
- R2: During an engine strobe, `eng_src_o` equals address bits [4:3] of the access that caused it.
- R3: Each access with address bit 5 = 0 produces exactly one one-cycle strobe. A read raises `eng_rd_o` and a write raises `eng_wr_o`. For a write, `eng_din_o` equals write data bits [DATA_W-1:0].
- R4: An access with address bit 5 = 1 produces no engine strobe.
- R5: Consider an engine access whose engine stays busy for L cycles after the strobe. `bus_wait_o` is high for exactly L+3 cycles from the cycle the request appears. It is then low for one cycle.
- R6: A control/status access (address bit 5 = 1) completes with `bus_wait_o` low in its first cycle.
- R7: Control/status bit 0 is read/write. `eng_reconfig_o` follows its stored value, and the value changes only on a control/status write.
- R8: Control/status bit 1 is read/write, and `eng_wdt_rst_o` follows its stored value.
- R9: Control/status bits 31:2 read as zero, and writes to them have no effect.
- R10: Read data from the engine appears on `bus_rdata_o` zero-extended from DATA_W to 32 bits.
- R11: After reset, both control bits are 0, no strobe is active, and `bus_wait_o` is low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Word address |
| bus_cs_i | input | 1 | Slave select |
| bus_rd_i | input | 1 | Read request |
| bus_wr_i | input | 1 | Write request |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_wait_o | output | 1 | Stall while high |
| eng_param_o | output | 3 | Parameter select to engine |
| eng_src_o | output | 2 | Source select to engine |
| eng_rd_o | output | 1 | Engine read strobe |
| eng_wr_o | output | 1 | Engine write strobe |
| eng_din_o | output | DATA_W | Write data to engine |
| eng_dout_i | input | DATA_W | Read data from engine |
| eng_busy_i | input | 1 | Engine busy |
| eng_reconfig_o | output | 1 | Reconfigure request |
| eng_wdt_rst_o | output | 1 | Watchdog timer reset |

## Verification
The hardest situation to reach from the ports is the exact length of the stall. It depends on how long the engine's busy response lasts, including a busy that never rises at all. The bench uses a behavioural engine whose busy length rotates from 0 to 3 cycles. It sweeps all 32 engine offsets as reads and writes against that engine, and it counts stall cycles against L+3. The control/status region is then swept at every upper offset, with mixed reserved-bit patterns. Throughout this sweep the bench confirms that no strobe leaks to the engine.

// File: rtl/rup_pkg.sv
package rup_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned PARAM_W = 3;
  localparam int unsigned SRC_W   = 2;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CSR_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/rup_decode.sv
module rup_decode
  import rup_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               cs_i,
  input  logic               rd_i,
  input  logic               wr_i,
  output logic [PARAM_W-1:0] param_o,
  output logic [SRC_W-1:0]   src_o,
  output logic               eng_req_o,
  output logic               csr_req_o,
  output logic               csr_wr_o
);
  localparam int unsigned SEL_BIT = PARAM_W + SRC_W;

  logic req;
  assign req       = cs_i & (rd_i | wr_i);
  assign param_o   = addr_i[PARAM_W-1:0];
  assign src_o     = addr_i[SEL_BIT-1:PARAM_W];
  assign eng_req_o = req & ~addr_i[SEL_BIT];
  assign csr_req_o = req &  addr_i[SEL_BIT];
  assign csr_wr_o  = cs_i & wr_i & addr_i[SEL_BIT];
endmodule

// File: rtl/rup_csr.sv
module rup_csr
  import rup_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] csr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   csr_o <= '0;
    else if (wr_i) csr_o <= wdata_i;
  end
endmodule

// File: rtl/rup_seq.sv
module rup_seq
  import rup_pkg::*;
#(
  parameter int unsigned DATA_W = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               is_wr_i,
  input  logic [PARAM_W-1:0] param_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  dout_i,
  input  logic               busy_i,
  output logic               rd_o,
  output logic               wr_o,
  output logic [PARAM_W-1:0] param_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [DATA_W-1:0]  din_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               done_o,
  output logic               hold_o
);
  seq_st_e st_q, st_d;
  logic    is_wr_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (!busy_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      is_wr_q <= 1'b0;
      param_o <= '0;
      src_o   <= '0;
      din_o   <= '0;
      rdata_o <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) begin
        is_wr_q <= is_wr_i;
        param_o <= param_i;
        src_o   <= src_i;
        din_o   <= wdata_i;
      end
      // capture once busy has cleared
      if (st_q == ST_WAIT && !busy_i) rdata_o <= dout_i;
    end
  end

  assign rd_o   = (st_q == ST_ISSUE) & ~is_wr_q;
  assign wr_o   = (st_q == ST_ISSUE) &  is_wr_q;
  assign done_o = (st_q == ST_DONE);
  assign hold_o = (st_q == ST_IDLE && req_i) || st_q == ST_ISSUE || st_q == ST_WAIT;
endmodule

// File: rtl/rup_bridge.sv
module rup_bridge
  import rup_pkg::*;
#(
  parameter int unsigned DATA_W = 22
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [5:0]         bus_addr_i,
  input  logic               bus_cs_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               bus_wait_o,
  output logic [2:0]         eng_param_o,
  output logic [1:0]         eng_src_o,
  output logic               eng_rd_o,
  output logic               eng_wr_o,
  output logic [DATA_W-1:0]  eng_din_o,
  input  logic [DATA_W-1:0]  eng_dout_i,
  input  logic               eng_busy_i,
  output logic               eng_reconfig_o,
  output logic               eng_wdt_rst_o
);
  logic [PARAM_W-1:0] dec_param;
  logic [SRC_W-1:0]   dec_src;
  logic               eng_req, csr_req, csr_wr;
  logic [CSR_W-1:0]   csr_q;
  logic [DATA_W-1:0]  eng_rdata;
  logic               seq_done, seq_hold;

  rup_decode u_dec (
    .addr_i    (bus_addr_i),
    .cs_i      (bus_cs_i),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .param_o   (dec_param),
    .src_o     (dec_src),
    .eng_req_o (eng_req),
    .csr_req_o (csr_req),
    .csr_wr_o  (csr_wr)
  );

  rup_csr u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (csr_wr),
    .wdata_i (bus_wdata_i[CSR_W-1:0]),
    .csr_o   (csr_q)
  );

  rup_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (eng_req),
    .is_wr_i (bus_wr_i),
    .param_i (dec_param),
    .src_i   (dec_src),
    .wdata_i (bus_wdata_i[DATA_W-1:0]),
    .dout_i  (eng_dout_i),
    .busy_i  (eng_busy_i),
    .rd_o    (eng_rd_o),
    .wr_o    (eng_wr_o),
    .param_o (eng_param_o),
    .src_o   (eng_src_o),
    .din_o   (eng_din_o),
    .rdata_o (eng_rdata),
    .done_o  (seq_done),
    .hold_o  (seq_hold)
  );

  logic csr_rd_unused;
  assign csr_rd_unused = csr_req;

  assign bus_wait_o     = seq_hold;
  assign bus_rdata_o    = seq_done ? BUS_W'(eng_rdata) : BUS_W'(csr_q);
  assign eng_reconfig_o = csr_q[0];
  assign eng_wdt_rst_o  = csr_q[1];
endmodule

// File: rtl/rup_bridge_chk.sv
module rup_bridge_chk #(
  parameter int unsigned DATA_W = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [5:0]        bus_addr_i,
  input logic              bus_cs_i,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic              bus_wait_o,
  input logic [2:0]        eng_param_o,
  input logic [1:0]        eng_src_o,
  input logic              eng_rd_o,
  input logic              eng_wr_o,
  input logic              eng_busy_i,
  input logic              eng_reconfig_o
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rd_o || eng_wr_o) |=> !(eng_rd_o || eng_wr_o)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_rd_o && eng_wr_o)); // R3
  AST_PARAM_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rd_o || eng_wr_o) |-> eng_param_o == $past(bus_addr_i[2:0])); // R1
  AST_SRC_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rd_o || eng_wr_o) |-> eng_src_o == $past(bus_addr_i[4:3])); // R2
  AST_STROBE_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rd_o || eng_wr_o) |-> $past(bus_cs_i && !bus_addr_i[5])); // R4
  AST_CSR_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_i && (bus_rd_i || bus_wr_i) && bus_addr_i[5]) |-> !bus_wait_o); // R6
  AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_wait_o) && bus_cs_i && !bus_addr_i[5]) |-> $past(!eng_busy_i)); // R5
  AST_RECONF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_cs_i && bus_wr_i && bus_addr_i[5]) |=> $stable(eng_reconfig_o)); // R7
endmodule

bind rup_bridge rup_bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rup_bridge.sv
module sim_rup_bridge;
  localparam int DW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    addr = '0;
  logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          wait_s;
  logic [2:0]    e_param;
  logic [1:0]    e_src;
  logic          e_rd, e_wr, e_reconf, e_wdt;
  logic [DW-1:0] e_din;
  logic [DW-1:0] e_dout;
  logic          e_busy;

  int vectors = 0, miscompares = 0;
  int lat = 0, bcnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [2:0]    last_param;
  logic [1:0]    last_src;
  logic [DW-1:0] last_din;

  always #10 clk = ~clk;

  rup_bridge #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_cs_i(cs),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_wait_o(wait_s), .eng_param_o(e_param), .eng_src_o(e_src),
    .eng_rd_o(e_rd), .eng_wr_o(e_wr), .eng_din_o(e_din), .eng_dout_i(e_dout),
    .eng_busy_i(e_busy), .eng_reconfig_o(e_reconf), .eng_wdt_rst_o(e_wdt)
  );

  function automatic logic [DW-1:0] eng_val(input logic [4:0] sel);
    return DW'(22'h3C0000) ^ (DW'(sel) * DW'(4099));
  endfunction

  // behavioural engine: busy for lat cycles after each strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_busy <= 1'b0; bcnt <= 0; e_dout <= '0;
    end else if (e_rd || e_wr) begin
      e_busy <= (lat > 0); bcnt <= lat;
      e_dout <= eng_val({e_src, e_param});
      if (e_rd) rd_cnt <= rd_cnt + 1;
      if (e_wr) wr_cnt <= wr_cnt + 1;
      last_param <= e_param; last_src <= e_src; last_din <= e_din;
    end else if (e_busy) begin
      e_busy <= (bcnt > 1); bcnt <= bcnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [5:0] a, input logic w, input logic [31:0] wd,
                        output logic [31:0] rv, output int waits);
    addr = a; cs = 1'b1; rd = ~w; wr = w; wdata = wd; waits = 0;
    #1;
    while (wait_s) begin
      waits++;
      @(negedge clk); #1;
    end
    rv = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [31:0] rv;
    int waits, r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!e_reconf && !e_wdt, "R11 ctrl bits", {e_wdt, e_reconf}, 0);
    chk(!wait_s && !e_rd && !e_wr, "R11 idle", {wait_s, e_rd, e_wr}, 0);

    // engine sweep: all 32 offsets, read and write, busy 0..3
    for (int a = 0; a < 32; a++) begin
      for (int w = 0; w < 2; w++) begin
        logic [31:0] wd;
        wd = 32'hA5000000 ^ (32'(a) * 32'h01010123) ^ 32'(w);
        lat = (a + w) % 4;
        r0 = rd_cnt; w0 = wr_cnt;
        access(6'(a), w[0], wd, rv, waits);
        @(negedge clk);
        chk(last_param == a[2:0], "R1 param", last_param, a[2:0]);
        chk(last_src == a[4:3], "R2 src", last_src, a[4:3]);
        if (w == 1) begin
          chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R3 write strobe", wr_cnt - w0, 1);
          chk(last_din == wd[DW-1:0], "R3 din", last_din, wd[DW-1:0]);
        end else begin
          chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R3 read strobe", rd_cnt - r0, 1);
          chk(rv == 32'(eng_val(5'(a))), "R10 rdata", rv, 32'(eng_val(5'(a))));
        end
        chk(waits == lat + 3, "R5 wait cycles", waits, lat + 3);
      end
    end

    // CSR sweep over every upper offset
    for (int a = 32; a < 64; a++) begin
      logic [31:0] wd;
      logic [1:0]  exp;
      wd  = (32'(a) * 32'h9E3779B1) | 32'hFFF0_0000;
      exp = wd[1:0];
      r0 = rd_cnt; w0 = wr_cnt;
      access(6'(a), 1'b1, wd, rv, waits);
      chk(waits == 0, "R6 csr write no wait", waits, 0);
      #1;
      chk(e_reconf == exp[0], "R7 reconfig out", e_reconf, exp[0]);
      chk(e_wdt == exp[1], "R8 wdt out", e_wdt, exp[1]);
      access(6'(63 - (a - 32)), 1'b0, 32'h0, rv, waits);
      chk(waits == 0, "R6 csr read no wait", waits, 0);
      chk(rv == {30'b0, exp}, "R9 csr readback", rv, {30'b0, exp});
      @(negedge clk);
      chk(rd_cnt == r0 && wr_cnt == w0, "R4 no engine strobe", (rd_cnt - r0) + (wr_cnt - w0), 0);
    end

    // R8 watchdog reset set then clear; R7 reconfig remains as written
    access(6'h20, 1'b1, 32'h2, rv, waits); #1;
    chk(e_wdt && !e_reconf, "R8 wdt set", {e_wdt, e_reconf}, 2'b10);
    access(6'h20, 1'b1, 32'h0, rv, waits); #1;
    chk(!e_wdt && !e_reconf, "R8 wdt clear", {e_wdt, e_reconf}, 0);
    // R9 reserved-only write leaves register at zero
    access(6'h3F, 1'b1, 32'hFFFF_FFFC, rv, waits);
    access(6'h2A, 1'b0, 32'h0, rv, waits);
    chk(rv == 32'h0, "R9 reserved ignored", rv, 0);
    // R7 reconfig held across engine traffic
    access(6'h21, 1'b1, 32'h1, rv, waits);
    lat = 2;
    access(6'h05, 1'b0, 32'h0, rv, waits);
    #1;
    chk(e_reconf, "R7 reconfig held", e_reconf, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule